// File: doc/BRIEF.md
# DLL Output Phase Programming Sequencer

This block owns the 32-bit control word of a clock-data-recovery delay line and moves it to a new sampling phase, 0 to 15, without glitching the recovered clock. A single start pulse with a 4-bit phase launches a fixed series of writes to the word. First the recovery loop and the clock output are switched off and the external phase select is switched on. Then the phase is written in reflected Gray code. Then the clock output is switched back on. Last, the recovery loop is handed back to internal control.

Between the writes the sequencer watches the clock-output-enable status that the delay line returns. It samples that status once when each wait begins and again on every tick of an internal microsecond prescaler, up to a parameterised number of samples. If a wait runs out of samples, the sequence stops with an error and the final write is skipped. Otherwise it ends with a done pulse. A tuning engine uses the block by issuing one start per candidate phase and then one more for the chosen phase.

Top module: `dll_phase_seq`

## Requirements
- R1: After reset, `cfg_o` equals the parameter `CFG_RESET`, and `busy_o`, `done_o` and `err_o` are 0.
- R2: One cycle after an accepted start, `cfg_o` has bit 17 (loop enable) and bit 18 (clock-output enable) at 0, and bit 16 (delay enable) and bit 19 (external select) at 1. All other bits keep their earlier value.
- R3: The first wait samples `ck_out_sts_i` in its first cycle and then on every prescaler tick, with ticks TICK_DIV cycles apart and the first tick TICK_DIV-1 cycles after entry. It takes at most MAX_SAMPLES samples. A sample that reads 0 ends the wait successfully.
- R4: If none of the first wait's samples reads 0, `err_o` pulses for one cycle and `busy_o` falls. `cfg_o` keeps the R2 value, so bit 17 stays 0 and bit 19 stays 1.
- R5: After the first wait, bits 23:20 of `cfg_o` take the reflected Gray code g = p XOR (p >> 1) of the phase p latched at start (0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8). No other bit changes in that write.
- R6: After the phase write, bit 18 is set. A second wait then runs with the same sampling rule as R3 and ends when the status reads 1.
- R7: On success, the final write sets bit 17 and clears bit 19. `done_o` pulses for one cycle together with that word, and `busy_o` is 0 in that cycle.
- R8: If the second wait runs out of samples, `err_o` pulses and `cfg_o` holds the R5 field with bit 18 at 1, bit 19 at 1 and bit 17 at 0.
- R9: A start that arrives while `busy_o` is 1 is ignored: the running phase is kept and no extra done or error occurs. While idle without a start, `cfg_o` does not change.
- R10: `busy_o` is 1 from the cycle after an accepted start until the cycle of `done_o` or `err_o`. Exactly one of the two pulses follows each accepted start, and they never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| phase_i | input | 4 | Requested output phase, 0 to 15 |
| ck_out_sts_i | input | 1 | Clock-output-enable status from the delay line |
| cfg_o | output | 32 | Delay-line control word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: sequence completed |
| err_o | output | 1 | One-cycle pulse: a wait ran out of samples |

## Verification
The bench builds the block with TICK_DIV = 4 and MAX_SAMPLES = 6, so the last sample of each wait falls 19 cycles after the wait begins. With these values, a delay-line model of 19 cycles of latency just passes and one of 20 cycles just fails, in both the falling wait and the rising wait. A reset word with bits scattered across the whole register shows that untouched bits are preserved. Stuck-high and stuck-low status modes reach each abort path, and a sweep of all sixteen phases covers the whole Gray mapping.

// File: rtl/dll_phase_pkg.sv
package dll_phase_pkg;
    localparam int CFG_W       = 32;
    localparam int PH_W        = 4;
    localparam int POS_DLL_EN  = 16;
    localparam int POS_CDR_EN  = 17;
    localparam int POS_CKO_EN  = 18;
    localparam int POS_EXT_SEL = 19;
    localparam int POS_PH_LSB  = 20;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_OFF,
        S_WR_PHASE,
        S_WR_ON,
        S_WAIT_ON,
        S_WR_CDR
    } seq_state_e;

    typedef struct packed {
        seq_state_e          state;
        logic [CFG_W-1:0]    cfg;
        logic [PH_W-1:0]     phase;
        logic                done;
        logic                err;
    } seq_regs_t;
endpackage

// File: rtl/dll_phase_tick.sv
// Microsecond prescaler: counts while enabled, held at zero otherwise.
module dll_phase_tick #(
    parameter int TICK_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = en_i && (cnt_q == LAST);
        if (!en_i || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/dll_phase_gray.sv
// Binary to reflected Gray code, one XOR per bit below the top.
module dll_phase_gray #(
    parameter int W = 4
) (
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] gray_o
);
    assign gray_o[W-1] = bin_i[W-1];
    for (genvar i = 0; i < W - 1; i++) begin : g_bit
        assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
    end
endmodule

// File: rtl/dll_phase_poll.sv
// Bounded status poll: samples on entry and on each tick, up to MAX_SAMPLES.
module dll_phase_poll #(
    parameter int MAX_SAMPLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic tick_i,
    input  logic sts_i,
    input  logic want_i,
    output logic hit_o,
    output logic expire_o
);
    localparam int CW = (MAX_SAMPLES > 1) ? $clog2(MAX_SAMPLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(MAX_SAMPLES - 1);

    logic [CW-1:0] smp_d, smp_q;
    logic          sample;
    logic          match;

    always_comb begin
        sample   = active_i && ((smp_q == '0) || tick_i);
        match    = (sts_i == want_i);
        hit_o    = sample && match;
        expire_o = sample && !match && (smp_q == LAST);
        smp_d    = smp_q;
        if (!active_i || hit_o || expire_o) begin
            smp_d = '0;
        end else if (sample) begin
            smp_d = smp_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end
endmodule

// File: rtl/dll_phase_seq.sv
module dll_phase_seq
    import dll_phase_pkg::*;
#(
    parameter int          TICK_DIV    = 100,
    parameter int          MAX_SAMPLES = 50,
    parameter logic [31:0] CFG_RESET   = 32'h0005_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [3:0]  phase_i,
    input  logic        ck_out_sts_i,
    output logic [31:0] cfg_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o
);
    seq_regs_t        r_d, r_q;
    logic             wait_active;
    logic             want_level;
    logic             tick;
    logic             hit;
    logic             expire;
    logic [PH_W-1:0]  gray_w;

    assign wait_active = (r_q.state == S_WAIT_OFF) || (r_q.state == S_WAIT_ON);
    assign want_level  = (r_q.state == S_WAIT_ON);

    dll_phase_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (wait_active),
        .tick_o (tick)
    );

    dll_phase_poll #(.MAX_SAMPLES(MAX_SAMPLES)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (wait_active),
        .tick_i   (tick),
        .sts_i    (ck_out_sts_i),
        .want_i   (want_level),
        .hit_o    (hit),
        .expire_o (expire)
    );

    dll_phase_gray #(.W(PH_W)) u_gray (
        .bin_i  (r_q.phase),
        .gray_o (gray_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.state)
            S_IDLE: begin
                if (start_i) begin
                    r_d.phase               = phase_i;
                    r_d.cfg[POS_CDR_EN]     = 1'b0;
                    r_d.cfg[POS_CKO_EN]     = 1'b0;
                    r_d.cfg[POS_EXT_SEL]    = 1'b1;
                    r_d.cfg[POS_DLL_EN]     = 1'b1;
                    r_d.state               = S_WAIT_OFF;
                end
            end
            S_WAIT_OFF: begin
                if (hit) begin
                    r_d.state = S_WR_PHASE;
                end else if (expire) begin
                    r_d.err   = 1'b1;
                    r_d.state = S_IDLE;
                end
            end
            S_WR_PHASE: begin
                r_d.cfg[POS_PH_LSB +: PH_W] = gray_w;
                r_d.state                   = S_WR_ON;
            end
            S_WR_ON: begin
                r_d.cfg[POS_CKO_EN] = 1'b1;
                r_d.state           = S_WAIT_ON;
            end
            S_WAIT_ON: begin
                if (hit) begin
                    r_d.state = S_WR_CDR;
                end else if (expire) begin
                    r_d.err   = 1'b1;
                    r_d.state = S_IDLE;
                end
            end
            S_WR_CDR: begin
                r_d.cfg[POS_CDR_EN]  = 1'b1;
                r_d.cfg[POS_EXT_SEL] = 1'b0;
                r_d.done             = 1'b1;
                r_d.state            = S_IDLE;
            end
            default: begin
                r_d.state = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= S_IDLE;
            r_q.cfg   <= CFG_RESET;
            r_q.phase <= '0;
            r_q.done  <= 1'b0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_o  = r_q.cfg;
    assign busy_o = (r_q.state != S_IDLE);
    assign done_o = r_q.done;
    assign err_o  = r_q.err;
endmodule

// File: rtl/dll_phase_seq_chk.sv
module dll_phase_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [31:0] cfg_o,
    input logic        busy_o,
    input logic        done_o,
    input logic        err_o
);
    assert_first_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!cfg_o[17] && !cfg_o[18] && cfg_o[19] && cfg_o[16]));

    assert_abort_no_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!cfg_o[17] && cfg_o[19]));

    assert_final_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cfg_o[17] && !cfg_o[19] && cfg_o[18] && !busy_o));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(cfg_o));

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    assert_busy_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |-> ($past(busy_o) && !busy_o));
endmodule

bind dll_phase_seq dll_phase_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .cfg_o   (cfg_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o)
);

// File: tb/dll_phase_seq_test.sv
module dll_phase_seq_test;
    localparam int          TDIV     = 4;
    localparam int          NSMP     = 6;
    localparam logic [31:0] RST_WORD = 32'h8A05_C3A5;

    typedef struct packed {
        logic        err;
        logic [31:0] word;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  phase_i = 4'd0;
    logic        ck_out_sts_i;
    logic [31:0] cfg_o;
    logic        busy_o;
    logic        done_o;
    logic        err_o;

    int          lat = 0;
    int          mode = 0;
    logic [31:0] hist = '1;
    exp_t        sbq[$];
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    logic [31:0] model_word;

    dll_phase_seq #(.TICK_DIV(TDIV), .MAX_SAMPLES(NSMP), .CFG_RESET(RST_WORD)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .phase_i      (phase_i),
        .ck_out_sts_i (ck_out_sts_i),
        .cfg_o        (cfg_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o)
    );

    always #4 clk = ~clk;

    // Delay-line model: status follows clock-output enable after lat cycles.
    always @(posedge clk) hist <= {hist[30:0], cfg_o[18]};
    assign ck_out_sts_i = (mode == 1) ? 1'b1 :
                          (mode == 2) ? 1'b0 :
                          ((lat == 0) ? cfg_o[18] : hist[lat-1]);

    function automatic logic [3:0] gray4(input logic [3:0] p);
        return p ^ (p >> 1);
    endfunction

    task automatic check_w(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected outcomes as the design reports them.
    always @(negedge clk) begin
        if (rst_n && (done_o || err_o)) begin
            if (sbq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10/R9: actual unexpected outcome (done=%0b err=%0b) expected none",
                         done_o, err_o);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check_w("R4/R7/R8 outcome err flag", {31'd0, err_o}, {31'd0, e.err});
                check_w("R10 done is not err", {31'd0, done_o}, {31'd0, ~e.err});
                check_w("R5/R7/R8 final cfg word", cfg_o, e.word);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    task automatic run(input logic [3:0] ph, input int l, input int m, input int inj_at);
        logic [31:0] w1, w2, w3;
        logic        pass1, pass2;
        exp_t        e;
        int          n;
        logic        busy_ok;
        @(negedge clk);
        lat  = l;
        mode = m;
        w1 = model_word;
        w1[17] = 1'b0; w1[18] = 1'b0; w1[19] = 1'b1; w1[16] = 1'b1;
        pass1 = (m != 1) && ((model_word[18] == 1'b0) || (m == 2) || (l <= 19));
        w2 = w1;
        w2[23:20] = gray4(ph);
        w2[18] = 1'b1;
        pass2 = (m != 2) && ((m == 1) || (l <= 19));
        w3 = w2;
        w3[17] = 1'b1; w3[19] = 1'b0;
        if (!pass1)      e = '{err: 1'b1, word: w1};
        else if (!pass2) e = '{err: 1'b1, word: w2};
        else             e = '{err: 1'b0, word: w3};
        sbq.push_back(e);
        model_word = e.word;
        phase_i = ph;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check_w("R2 first write word", cfg_o, w1);
        busy_ok = 1'b1;
        n = 0;
        while (!(done_o || err_o) && n < 200) begin
            if (!busy_o) busy_ok = 1'b0;
            if (inj_at != 0 && n == inj_at) begin
                phase_i = ~ph;
                start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            n++;
        end
        check_w("R10 busy held through run", {31'd0, busy_ok}, 32'd1);
        check_w("R10 busy low at outcome", {31'd0, busy_o}, 32'd0);
        repeat (30) @(negedge clk);
        check_w("R9 idle word unchanged", cfg_o, model_word);
    endtask

    initial begin
        model_word = RST_WORD;
        repeat (3) @(negedge clk);
        check_w("R1 reset cfg", cfg_o, RST_WORD);
        check_w("R1 reset flags", {29'd0, busy_o, done_o, err_o}, 32'd0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        check_w("R9 idle without start", cfg_o, RST_WORD);

        run(4'd0, 2, 0, 0);     // R3 R5 R6 R7 normal
        run(4'd5, 0, 0, 0);     // zero latency
        run(4'd15, 19, 0, 0);   // R3 R6 last sample catches status
        run(4'd10, 20, 0, 0);   // R4 first wait misses last sample
        run(4'd7, 20, 0, 0);    // R8 second wait misses last sample
        run(4'd3, 0, 2, 0);     // R8 status stuck low
        run(4'd12, 0, 1, 0);    // R4 status stuck high
        run(4'd9, 3, 0, 5);     // R9 start during busy ignored
        run(4'd6, 4, 0, 12);    // R9 start during second wait ignored
        for (int p = 0; p < 16; p++) begin
            run(p[3:0], 1, 0, 0);   // R5 full Gray sweep
        end

        repeat (10) @(negedge clk);
        check_w("R10 every start produced one outcome", sbq.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule